// File: doc/BRIEF.md
# Dual Clock Frequency Comparator

The block judges whether a monitored clock runs at the rate software expects, measured against a reference clock, while the application keeps running. Two counters count down from software-loaded start values, one on each clock. The reference counter marks out a fixed time base. When it runs out, a programmable valid window opens, also timed on the reference clock. A check passes only when the monitored counter reaches zero while that window is open. Reaching zero too early, or not reaching it before the window closes, raises a sticky error. Software picks the three start values so that a clock at the nominal ratio finishes inside the window.

After a pass, both counters reload and the next check starts without software help. After a failure the block holds the error until software clears it. Each check also records how many monitored-clock cycles fell inside the reference time base, so software can read back the actual frequency. Control and read-back use a small register port in the reference domain. The start, zero and capture events cross between domains as toggles through two-flop synchronizers. The multi-bit measured count is taken across only after a synchronized acknowledge.

The control state machine has four states. CK_IDLE waits for software. CK_REF_RUN runs the reference time base. CK_WINDOW holds the valid window open. CK_FAULT keeps the error. The named transitions are: go (CK_IDLE to CK_REF_RUN), early (CK_REF_RUN to CK_FAULT on a monitored zero), open (CK_REF_RUN to CK_WINDOW when the reference count is spent), pass (CK_WINDOW to CK_REF_RUN on a monitored zero), late (CK_WINDOW to CK_FAULT when the window count is spent), clear (any state to CK_IDLE) and clear_go (any state to CK_REF_RUN).

Top module: `clk_ratio_checker`

## Requirements
- R1: After reset, err and done are 0 and every read address returns 0.
- R2: Writes to address 0 (reference start value), 1 (monitored start value) and 2 (window length) are read back unchanged at the same address.
- R3: A write to address 3 with bit 0 set starts checking from the idle state. With a monitored clock at the nominal ratio, done pulses and err stays 0.
- R4: If the monitored counter reaches zero while the reference time base is still running, err rises before the time base ends, and no done pulse occurs.
- R5: If the monitored counter has not reached zero when the window count is spent, err rises. This covers both a slow and a stopped monitored clock.
- R6: After each pass, the check restarts by itself. Successive done pulses are spaced by one full time base plus part of the window: 100 to 130 reference cycles for the bench settings.
- R7: Once set, err stays 1 and done stays 0 until a write to address 3 with bit 1 set. That write clears err, and the block then stays idle (no done, no err) until started again.
- R8: Reading address 3 returns the number of monitored-clock cycles counted during the last completed reference time base. The value does not change when the monitored clock delivers no capture.
- R9: done is a single-cycle pulse and is never high together with err.
- R10: A write to address 3 with bits 1 and 0 both set, while faulted, clears err and restarts checking directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also clocks the register port |
| mon_clk | input | 1 | Clock under supervision |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CW | Read data (start values, or measured count at address 3) |
| err | output | 1 | Sticky out-of-tolerance flag |
| done | output | 1 | One-cycle pulse per passed check |

## Verification
Two events can meet in one reference cycle: a software clear and a start can arrive in the same write while the block is faulted. Also, the monitored zero event can land in the same cycle that a check's outcome is decided. The bench provokes the first case by writing both control bits in one write while err is held. It then expects err low on the next sample and done pulses to resume at the nominal spacing. A behavioural model in the bench tracks the expected phase on every reference clock (clean run, held fault or idle) and flags any done or err that disagrees with it.

// File: rtl/ckchk_pkg.sv
package ckchk_pkg;

    typedef enum logic [1:0] {
        CK_IDLE    = 2'd0,
        CK_REF_RUN = 2'd1,
        CK_WINDOW  = 2'd2,
        CK_FAULT   = 2'd3
    } ck_state_t;

    localparam logic [1:0] ADDR_REF_SEED = 2'd0;
    localparam logic [1:0] ADDR_MON_SEED = 2'd1;
    localparam logic [1:0] ADDR_WIN_SEED = 2'd2;
    localparam logic [1:0] ADDR_CTRL     = 2'd3;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;

endpackage

// File: rtl/ckchk_tsync.sv
// Toggle synchronizer: a level toggle from a foreign domain becomes a
// one-cycle event in the local domain.
module ckchk_tsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic evt
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], tgl_in};
            last  <= chain[STAGES-1];
        end
    end

    assign evt = chain[STAGES-1] ^ last;

endmodule

// File: rtl/ckchk_mon_side.sv
// Monitored-clock domain: seeded down-counter plus elapsed-cycle counter.
module ckchk_mon_side #(
    parameter int CW     = 16,
    parameter int STAGES = 2
) (
    input  logic          mon_clk,
    input  logic          rst_n,
    input  logic          start_tgl,
    input  logic [CW-1:0] seed,
    input  logic          cap_tgl,
    output logic          zero_tgl,
    output logic          ack_tgl,
    output logic [CW-1:0] hold
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic          start_evt;
    logic          cap_evt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] elapsed;
    logic          running;
    logic          meas_on;

    ckchk_tsync #(.STAGES(STAGES)) u_start_sync (
        .clk(mon_clk), .rst_n(rst_n), .tgl_in(start_tgl), .evt(start_evt)
    );

    ckchk_tsync #(.STAGES(STAGES)) u_cap_sync (
        .clk(mon_clk), .rst_n(rst_n), .tgl_in(cap_tgl), .evt(cap_evt)
    );

    // Seeded down-counter; one zero toggle per run.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            running  <= 1'b0;
            zero_tgl <= 1'b0;
        end else if (start_evt) begin
            cnt     <= seed;
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) begin
                zero_tgl <= ~zero_tgl;
                running  <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Elapsed counter: runs from launch until the capture request arrives.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
            meas_on <= 1'b0;
            hold    <= '0;
            ack_tgl <= 1'b0;
        end else begin
            if (cap_evt) begin
                hold    <= elapsed;
                ack_tgl <= ~ack_tgl;
                meas_on <= 1'b0;
            end else if (start_evt) begin
                elapsed <= '0;
                meas_on <= 1'b1;
            end else if (meas_on && elapsed != CNT_MAX) begin
                elapsed <= elapsed + 1'b1;
            end
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !cap_evt |=> $stable(hold));

    // R5
    zero_only_running_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (zero_tgl != $past(zero_tgl)) |-> $past(running));

endmodule

// File: rtl/ckchk_ctrl.sv
// Reference-domain control FSM: time base, valid window, verdict.
module ckchk_ctrl
    import ckchk_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic          go_cmd,
    input  logic          clr_cmd,
    input  logic [CW-1:0] ref_seed,
    input  logic [CW-1:0] win_seed,
    input  logic          zero_evt,
    output logic          start_tgl,
    output logic          cap_tgl,
    output logic          err,
    output logic          done
);
    ck_state_t     state, nxt;
    logic [CW-1:0] ref_cnt;
    logic [CW-1:0] win_cnt;
    logic          launch;
    logic          cap_req;
    logic          pass;

    // State register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state <= CK_IDLE;
        else        state <= nxt;
    end

    // Next state and named transitions
    always_comb begin
        nxt     = state;
        launch  = 1'b0;
        cap_req = 1'b0;
        pass    = 1'b0;
        if (clr_cmd) begin
            // clear / clear_go
            nxt    = go_cmd ? CK_REF_RUN : CK_IDLE;
            launch = go_cmd;
        end else begin
            unique case (state)
                CK_IDLE: begin
                    if (go_cmd) begin            // go
                        nxt    = CK_REF_RUN;
                        launch = 1'b1;
                    end
                end
                CK_REF_RUN: begin
                    if (zero_evt) begin          // early
                        nxt = CK_FAULT;
                    end else if (ref_cnt == '0) begin   // open
                        nxt     = CK_WINDOW;
                        cap_req = 1'b1;
                    end
                end
                CK_WINDOW: begin
                    if (zero_evt) begin          // pass
                        nxt    = CK_REF_RUN;
                        launch = 1'b1;
                        pass   = 1'b1;
                    end else if (win_cnt == '0) begin   // late
                        nxt = CK_FAULT;
                    end
                end
                CK_FAULT: begin
                    nxt = CK_FAULT;
                end
                default: nxt = CK_IDLE;
            endcase
        end
    end

    // Counters and cross-domain toggles
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt   <= '0;
            win_cnt   <= '0;
            start_tgl <= 1'b0;
            cap_tgl   <= 1'b0;
        end else begin
            if (launch) begin
                ref_cnt   <= ref_seed;
                start_tgl <= ~start_tgl;
            end else if (state == CK_REF_RUN && ref_cnt != '0) begin
                ref_cnt <= ref_cnt - 1'b1;
            end
            if (cap_req) begin
                win_cnt <= win_seed;
                cap_tgl <= ~cap_tgl;
            end else if (state == CK_WINDOW && win_cnt != '0) begin
                win_cnt <= win_cnt - 1'b1;
            end
        end
    end

    // Outputs
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            err  <= 1'b0;
            done <= 1'b0;
        end else begin
            err  <= (nxt == CK_FAULT);
            done <= pass;
        end
    end

    // R9
    done_err_excl_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(done && err));

    // R9
    done_pulse_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    err_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (err && !clr_cmd) |=> err);

    // R4
    fault_cause_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(err) |-> ($past(state) == CK_REF_RUN || $past(state) == CK_WINDOW));

endmodule

// File: rtl/clk_ratio_checker.sv
module clk_ratio_checker
    import ckchk_pkg::*;
#(
    parameter int CW     = 16,
    parameter int STAGES = 2
) (
    input  logic          ref_clk,
    input  logic          mon_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    output logic          err,
    output logic          done
);
    logic [CW-1:0] ref_seed;
    logic [CW-1:0] mon_seed;
    logic [CW-1:0] win_seed;
    logic [CW-1:0] meas;
    logic [CW-1:0] hold;
    logic          go_cmd;
    logic          clr_cmd;
    logic          start_tgl;
    logic          cap_tgl;
    logic          zero_tgl;
    logic          ack_tgl;
    logic          zero_evt;
    logic          ack_evt;

    assign go_cmd  = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CTRL_GO_BIT];
    assign clr_cmd = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CTRL_CLR_BIT];

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_seed <= '0;
            mon_seed <= '0;
            win_seed <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_REF_SEED: ref_seed <= wr_data;
                ADDR_MON_SEED: mon_seed <= wr_data;
                ADDR_WIN_SEED: win_seed <= wr_data;
                default: ;
            endcase
        end
    end

    // Measured count taken across only after the synchronized acknowledge
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)       meas <= '0;
        else if (ack_evt) meas <= hold;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_REF_SEED: rd_data = ref_seed;
            ADDR_MON_SEED: rd_data = mon_seed;
            ADDR_WIN_SEED: rd_data = win_seed;
            default:       rd_data = meas;
        endcase
    end

    ckchk_tsync #(.STAGES(STAGES)) u_zero_sync (
        .clk(ref_clk), .rst_n(rst_n), .tgl_in(zero_tgl), .evt(zero_evt)
    );

    ckchk_tsync #(.STAGES(STAGES)) u_ack_sync (
        .clk(ref_clk), .rst_n(rst_n), .tgl_in(ack_tgl), .evt(ack_evt)
    );

    ckchk_ctrl #(.CW(CW)) u_ctrl (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .go_cmd   (go_cmd),
        .clr_cmd  (clr_cmd),
        .ref_seed (ref_seed),
        .win_seed (win_seed),
        .zero_evt (zero_evt),
        .start_tgl(start_tgl),
        .cap_tgl  (cap_tgl),
        .err      (err),
        .done     (done)
    );

    ckchk_mon_side #(.CW(CW), .STAGES(STAGES)) u_mon (
        .mon_clk  (mon_clk),
        .rst_n    (rst_n),
        .start_tgl(start_tgl),
        .seed     (mon_seed),
        .cap_tgl  (cap_tgl),
        .zero_tgl (zero_tgl),
        .ack_tgl  (ack_tgl),
        .hold     (hold)
    );

    // R8
    meas_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !ack_evt |=> $stable(meas));

endmodule

// File: tb/clk_ratio_checker_bench.sv
`timescale 1ns/1ps
module clk_ratio_checker_bench;
    localparam int CW = 16;
    localparam int REF_SEED = 100;
    localparam int MON_SEED = 65;
    localparam int WIN_SEED = 20;

    logic          ref_clk = 1'b0;
    logic          mon_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic          wr_en   = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic          err;
    logic          done;

    int checks = 0;
    int errors = 0;
    realtime mon_half = 4.0;
    bit mon_run = 1'b1;

    // Expected phase model: 0 free, 1 clean run, 2 held fault, 3 idle
    int mode = 0;
    int cyc = 0;
    int done_cnt = 0;
    int last_done = -1;
    bit prev_done = 1'b0;

    clk_ratio_checker #(.CW(CW)) u_clk_ratio_checker (
        .ref_clk(ref_clk), .mon_clk(mon_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .err(err), .done(done)
    );

    always #2.5 ref_clk = ~ref_clk;

    initial begin
        forever begin
            if (mon_run) #(mon_half) mon_clk = ~mon_clk;
            else #1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input int d);
        @(negedge ref_clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = CW'(d);
        @(negedge ref_clk);
        wr_en   = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output int v);
        rd_addr = a;
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic wait_err(input int limit, output int took);
        took = 0;
        while (!err && took < limit) begin
            @(negedge ref_clk);
            took++;
        end
    endtask

    // Per-clock comparison against the phase model
    always @(negedge ref_clk) begin
        cyc++;
        if (rst_n) begin
            check(!(done && err), "R9 done with err", int'(done), 0);
            check(!(done && prev_done), "R9 done width", int'(done), 0);
            if (done) begin
                done_cnt++;
                if (mode == 1 && last_done >= 0)
                    check((cyc - last_done) >= 100 && (cyc - last_done) <= 130,
                          "R6 done spacing", cyc - last_done, 115);
                last_done = cyc;
            end
            if (mode == 1) check(err == 1'b0, "R3 err in clean run", int'(err), 0);
            if (mode == 2) begin
                check(err == 1'b1, "R7 err held", int'(err), 1);
                check(done == 1'b0, "R7 done while faulted", int'(done), 0);
            end
            if (mode == 3) begin
                check(err == 1'b0, "R7 err when idle", int'(err), 0);
                check(done == 1'b0, "R7 done when idle", int'(done), 0);
            end
        end
        prev_done = done;
    end

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL R3 watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int took;
        int meas_slow;

        wait_cyc(5);
        // R1 reset state
        check(err == 1'b0, "R1 err", int'(err), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), v);
            check(v == 0, "R1 register", v, 0);
        end
        rst_n = 1'b1;
        wait_cyc(3);

        // R2 start values read back
        reg_write(2'd0, REF_SEED);
        reg_write(2'd1, MON_SEED);
        reg_write(2'd2, WIN_SEED);
        reg_read(2'd0, v); check(v == REF_SEED, "R2 ref value", v, REF_SEED);
        reg_read(2'd1, v); check(v == MON_SEED, "R2 mon value", v, MON_SEED);
        reg_read(2'd2, v); check(v == WIN_SEED, "R2 win value", v, WIN_SEED);

        // R3 / R6 nominal ratio
        done_cnt = 0; last_done = -1;
        reg_write(2'd3, 1);
        mode = 1;
        wait_cyc(700);
        check(done_cnt >= 5, "R3 R6 passes at nominal", done_cnt, 5);
        reg_read(2'd3, v);
        check(v >= 59 && v <= 67, "R8 nominal measure", v, 63);

        // R4 too fast
        reg_write(2'd3, 2);
        mode = 3;
        mon_half = 3.0;
        wait_cyc(200);
        mode = 0; done_cnt = 0;
        reg_write(2'd3, 1);
        wait_err(400, took);
        check(err == 1'b1, "R4 err on fast clock", int'(err), 1);
        check(took < 101, "R4 err before time base end", took, 90);
        check(done_cnt == 0, "R4 no pass", done_cnt, 0);
        mode = 2;
        wait_cyc(100);

        // R5 too slow
        reg_write(2'd3, 2);
        mode = 3;
        mon_half = 5.0;
        wait_cyc(200);
        mode = 0; done_cnt = 0;
        reg_write(2'd3, 1);
        wait_err(400, took);
        check(err == 1'b1, "R5 err on slow clock", int'(err), 1);
        check(took >= 101 && took <= 130, "R5 err at window close", took, 122);
        check(done_cnt == 0, "R5 no pass slow", done_cnt, 0);
        mode = 2;
        wait_cyc(160);
        reg_read(2'd3, meas_slow);
        check(meas_slow >= 46 && meas_slow <= 54, "R8 slow measure", meas_slow, 50);

        // R5 stopped clock
        reg_write(2'd3, 2);
        mode = 3;
        mon_run = 1'b0;
        wait_cyc(20);
        mode = 0; done_cnt = 0;
        reg_write(2'd3, 1);
        wait_err(400, took);
        check(err == 1'b1, "R5 err on stopped clock", int'(err), 1);
        check(done_cnt == 0, "R5 no pass stopped", done_cnt, 0);
        mode = 2;
        wait_cyc(20);
        reg_read(2'd3, v);
        check(v == meas_slow, "R8 measure kept", v, meas_slow);

        // R7 fault held while clock recovers
        mon_half = 4.0;
        mon_run  = 1'b1;
        wait_cyc(200);

        // R10 clear and start together
        mode = 0; done_cnt = 0; last_done = -1;
        reg_write(2'd3, 3);
        check(err == 1'b0, "R10 err cleared", int'(err), 0);
        mode = 1;
        wait_cyc(500);
        check(done_cnt >= 3, "R10 passes after restart", done_cnt, 4);

        // R7 clear alone leaves block idle
        reg_write(2'd3, 2);
        mode = 3; done_cnt = 0;
        wait_cyc(300);
        check(done_cnt == 0, "R7 idle after clear", done_cnt, 0);
        check(err == 1'b0, "R7 err after clear", int'(err), 0);

        mode = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule